// File: doc/BRIEF.md
# SPI Register and Buffer Command Slave

This block is the serial front end of a small network controller. An SPI master (mode 0, active-low chip select) sends commands whose first byte holds a 3-bit opcode and a 5-bit register address. The slave then runs the access:
- reads and writes of control registers,
- bit-field set and clear,
- burst reads and writes of a packet buffer RAM, each with its own auto-incrementing pointer,
- a soft reset.

The register file, the pointers, the receive-window bounds and the buffer RAM are all held inside the block. The two buffer pointers are also brought out as ports.

All pins are sampled in the system clock domain. The serial clock must therefore run at no more than a quarter of the system clock. Registers fall into two timing classes:
- Registers in banks 2 and 3 below address 0x1B are slow. A read of one of them returns a dummy byte before the data.
- Every other register is fast.

A 2-bit bank field in a common control register selects which bank the lower addresses reach. The buffer read pointer walks a circular receive window.

Top module: `spi_regcmd_slave`

## Requirements
- R1: After reset, every register reads 0x00, except the clock-output register at 0x1E, which reads 0x04, and the receive-window end, which reads all ones (0x0A=0xFF, 0x0B=0x03 for a 10-bit pointer). Both pointer outputs read 0.
- R2: In the first byte of a command, bits 7:5 are the opcode and bits 4:0 are the address. The opcodes are:
  - 000 register read
  - 001 buffer read
  - 010 register write
  - 011 buffer write
  - 100 bit set
  - 101 bit clear
  - 111 soft reset, only as the full byte 0xFF

  Opcode 110 has no effect.
- R3: A read of a fast register shifts the register value out on MISO, MSB first, in the 8 clocks that follow the command byte.
- R4: A read of a slow register (bank 2 or 3, address below 0x1B) shifts out 0x00 first and then the register value in the next 8 clocks.
- R5: A register write stores the following byte in any fast or slow register.
- R6: Bit set ORs the data byte into a fast register, and bit clear clears the bits that are set in the data byte. On a slow register, both leave the value unchanged.
- R7: A buffer write stores each data byte of a burst at the write pointer and then increments the pointer. The pointer wraps from its maximum value to 0.
- R8: A buffer read returns the byte at the read pointer for each data byte of a burst and advances the pointer once per byte. The pointer steps from the window end (0x0A/0x0B) to the window start (0x08/0x09).
- R9: The byte 0xFF returns every register and both pointers to their reset values. The clock-output register at 0x1E keeps its value.
- R10: Raising chip select abandons a partial command with no effect. The next byte after chip select falls is decoded as a new command.
- R11: The bank field is bits 1:0 of the control register at 0x1F. Addresses 0x1B to 0x1F reach the same registers from every bank.
- R12: In bank 0, the pointers and window bounds are readable and writable as byte pairs (low byte at the lower address):
  - 0x00/0x01 read pointer
  - 0x02/0x03 write pointer
  - 0x08/0x09 window start
  - 0x0A/0x0B window end

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI clock, mode 0 |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave, low when not selected |
| rd_ptr | output | AW | Buffer read pointer |
| wr_ptr | output | AW | Buffer write pointer |

## Verification
During a buffer read burst, one completed data byte both advances the read pointer and fetches the next byte from the address just computed. When the pointer sits on the window end, that step also applies the wrap.

To provoke this, the bench loads a three-byte window starting mid-window and reads five bytes in one burst. The wrap then happens twice inside the same command. The bench judges the result by the returned byte order and by the final pointer value.

// File: rtl/spi_regcmd_slave.sv
module spi_regcmd_slave #(
  parameter int AW = 10,
  parameter logic [7:0] CLKOUT_RST = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr
);
  localparam int DEPTH = 1 << AW;
  localparam int HW = AW - 8;
  localparam logic [2:0] OP_RCR = 3'b000, OP_RBM = 3'b001, OP_WCR = 3'b010,
                         OP_WBM = 3'b011, OP_BFS = 3'b100, OP_BFC = 3'b101;

  typedef enum logic [2:0] {S_CMD, S_DUMMY, S_RDATA, S_WDATA, S_RBUF, S_WBUF, S_DONE} st_t;

  st_t st;
  logic          sck_q;
  logic [2:0]    cnt, op;
  logic [6:0]    sh;
  logic [7:0]    tx, ctrl, clkout, rv, nv;
  logic [4:0]    adr;
  logic [AW-1:0] rx_lo, rx_hi;
  logic [7:0]    regs [0:127];
  logic [7:0]    mem  [0:DEPTH-1];

  wire rise = ~cs_n & sck & ~sck_q;
  wire fall = ~cs_n & ~sck & sck_q;
  wire done = rise & (cnt == 3'd7);
  wire [7:0] rxb = {sh, mosi};
  wire [1:0] bank = ctrl[1:0];
  wire [4:0] sel_a = (st == S_CMD) ? rxb[4:0] : adr;
  wire is_mac = bank[1] & (sel_a < 5'h1B);
  wire is_ptr = (bank == 2'd0) & (sel_a inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h08, 5'h09, 5'h0A, 5'h0B});
  wire reg_we = done & (st == S_WDATA) & ((op == OP_WCR) | ~is_mac);
  wire soft_rst = done & (st == S_CMD) & (rxb == 8'hFF);
  wire [AW-1:0] rd_nxt = (rd_ptr == rx_hi) ? rx_lo : rd_ptr + 1'b1;

  function automatic logic [7:0] hi8(input logic [AW-1:0] p);
    return {{(16-AW){1'b0}}, p[AW-1:8]};
  endfunction

  assign miso = ~cs_n & tx[7];

  always_comb begin
    rv = regs[{bank, sel_a}];
    if (sel_a >= 5'h1B) rv = regs[{2'b00, sel_a}];
    if (sel_a == 5'h1F) rv = ctrl;
    if (sel_a == 5'h1E) rv = clkout;
    if (is_ptr)
      case (sel_a)
        5'h00:   rv = rd_ptr[7:0];
        5'h01:   rv = hi8(rd_ptr);
        5'h02:   rv = wr_ptr[7:0];
        5'h03:   rv = hi8(wr_ptr);
        5'h08:   rv = rx_lo[7:0];
        5'h09:   rv = hi8(rx_lo);
        5'h0A:   rv = rx_hi[7:0];
        default: rv = hi8(rx_hi);
      endcase
  end

  always_comb
    case (op)
      OP_WCR:  nv = rxb;
      OP_BFS:  nv = rv | rxb;
      default: nv = rv & ~rxb;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cnt <= '0; sh <= '0; tx <= '0; st <= S_CMD; op <= '0; adr <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        cnt <= '0; tx <= '0; st <= S_CMD;
      end else begin
        if (rise) begin
          sh  <= {sh[5:0], mosi};
          cnt <= cnt + 3'd1;
        end
        if (fall && cnt != 3'd0) tx <= {tx[6:0], 1'b0};
        if (done)
          case (st)
            S_CMD: begin
              op <= rxb[7:5]; adr <= rxb[4:0]; tx <= '0;
              if (rxb == 8'hFF) st <= S_DONE;
              else
                case (rxb[7:5])
                  OP_RCR: if (is_mac) st <= S_DUMMY;
                          else begin tx <= rv; st <= S_RDATA; end
                  OP_RBM: begin tx <= mem[rd_ptr]; st <= S_RBUF; end
                  OP_WBM: st <= S_WBUF;
                  OP_WCR, OP_BFS, OP_BFC: st <= S_WDATA;
                  default: st <= S_DONE;
                endcase
            end
            S_DUMMY: begin tx <= rv; st <= S_RDATA; end
            S_RBUF:  tx <= mem[rd_nxt];
            S_WBUF:  ;
            default: begin tx <= '0; st <= S_DONE; end
          endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ctrl <= '0; rd_ptr <= '0; wr_ptr <= '0; rx_lo <= '0; rx_hi <= '1;
      for (int i = 0; i < 128; i++) regs[i] <= '0;
    end else begin
      if (done && st == S_RBUF) rd_ptr <= rd_nxt;
      if (done && st == S_WBUF) wr_ptr <= wr_ptr + 1'b1;
      if (reg_we) begin
        if (adr == 5'h1F) ctrl <= nv;
        else if (adr >= 5'h1B) begin
          if (adr != 5'h1E) regs[{2'b00, adr}] <= nv;
        end else if (is_ptr)
          case (adr)
            5'h00:   rd_ptr[7:0]    <= nv;
            5'h01:   rd_ptr[AW-1:8] <= nv[HW-1:0];
            5'h02:   wr_ptr[7:0]    <= nv;
            5'h03:   wr_ptr[AW-1:8] <= nv[HW-1:0];
            5'h08:   rx_lo[7:0]     <= nv;
            5'h09:   rx_lo[AW-1:8]  <= nv[HW-1:0];
            5'h0A:   rx_hi[7:0]     <= nv;
            default: rx_hi[AW-1:8]  <= nv[HW-1:0];
          endcase
        else regs[{bank, adr}] <= nv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clkout <= CLKOUT_RST;
    else if (reg_we && adr == 5'h1E) clkout <= nv;
  end

  always_ff @(posedge clk)
    if (done && st == S_WBUF) mem[wr_ptr] <= rxb;

endmodule

// File: rtl/spi_regcmd_chk.sv
module spi_regcmd_chk #(parameter int AW = 10) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic [2:0]    cnt,
  input logic          reg_we,
  input logic          soft_rst,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rx_lo,
  input logic [7:0]    ctrl,
  input logic [7:0]    clkout
);
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == 3'd0));

  p_wr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !soft_rst) |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !soft_rst) |=> (rd_ptr == $past(rd_ptr)) || (rd_ptr == AW'($past(rd_ptr) + 1'b1)) || (rd_ptr == rx_lo));

  p_clkout_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(clkout));

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !soft_rst) |=> $stable(ctrl));
endmodule

bind spi_regcmd_slave spi_regcmd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cnt(cnt), .reg_we(reg_we),
  .soft_rst(soft_rst), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .rx_lo(rx_lo),
  .ctrl(ctrl), .clkout(clkout)
);

// File: tb/sim_spi_regcmd_slave.sv
module sim_spi_regcmd_slave;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0;
  wire miso;
  wire [9:0] rd_ptr, wr_ptr;
  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [7:0] v; string req; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  spi_regcmd_slave #(.AW(10)) u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr));

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic byte_x(input logic [7:0] d, input bit chk = 0, input logic [7:0] e = 0, input string req = "");
    logic [7:0] r;
    if (chk) begin
      item_t it;
      it.v = e; it.req = req;
      exp_q.push_back(it);
    end
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 0; mosi = d[i];
      repeat (2) @(negedge clk);
      r[i] = miso; sck = 1;
      repeat (2) @(negedge clk);
    end
    if (chk) got_q.push_back(r);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 0; repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); sck = 0; repeat (2) @(negedge clk);
    cs_n = 1; repeat (3) @(negedge clk);
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] d);
    sel(); byte_x(c); byte_x(d); desel();
  endtask

  task automatic rd_fast(input logic [4:0] a, input logic [7:0] e, input string req);
    sel(); byte_x({3'b000, a}); byte_x(8'h00, 1, e, req); desel();
  endtask

  task automatic rd_slow(input logic [4:0] a, input logic [7:0] e, input string req);
    sel(); byte_x({3'b000, a}); byte_x(8'h00, 1, 8'h00, req); byte_x(8'h00, 1, e, req); desel();
  endtask

  task automatic partial(input logic [7:0] c, input int nbits);
    sel();
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sck = 0; mosi = c[i];
      repeat (2) @(negedge clk); sck = 1; repeat (2) @(negedge clk);
    end
    desel();
  endtask

  initial forever begin
    item_t it;
    logic [7:0] g;
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      it = exp_q.pop_front();
      g = got_q.pop_front();
      check(it.req, {24'd0, g}, {24'd0, it.v});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 wr_ptr", wr_ptr, 0);
    rd_fast(5'h1F, 8'h00, "R1 ctrl");
    rd_fast(5'h1E, 8'h04, "R1 clkout");
    rd_fast(5'h05, 8'h00, "R1 reg05");

    cmd2(8'h45, 8'hA5);
    rd_fast(5'h05, 8'hA5, "R5 R3 write then read");
    cmd2(8'h85, 8'h0A);
    rd_fast(5'h05, 8'hAF, "R6 bit set");
    cmd2(8'hA5, 8'h81);
    rd_fast(5'h05, 8'h2E, "R6 bit clear");

    cmd2(8'h5F, 8'h02);
    cmd2(8'h44, 8'h3C);
    rd_slow(5'h04, 8'h3C, "R4 R5 slow read");
    cmd2(8'h84, 8'hFF);
    rd_slow(5'h04, 8'h3C, "R6 bit set ignored on slow");
    cmd2(8'hA4, 8'hFF);
    rd_slow(5'h04, 8'h3C, "R6 bit clear ignored on slow");
    rd_fast(5'h1E, 8'h04, "R11 common reg from bank 2");
    rd_slow(5'h05, 8'h00, "R11 bank 2 separate from bank 0");
    cmd2(8'hBF, 8'h03);
    rd_fast(5'h1F, 8'h00, "R11 R6 bank cleared");
    rd_fast(5'h05, 8'h2E, "R11 bank 0 back");

    cmd2(8'hC5, 8'h77);
    rd_fast(5'h05, 8'h2E, "R2 opcode 110 no effect");

    cmd2(8'h42, 8'hFE); cmd2(8'h43, 8'h03);
    check("R12 wr_ptr write", wr_ptr, 10'h3FE);
    sel(); byte_x(8'h7A); byte_x(8'h11); byte_x(8'h22); byte_x(8'h33); desel();
    check("R7 wr_ptr wrap", wr_ptr, 10'h001);
    cmd2(8'h40, 8'hFE); cmd2(8'h41, 8'h03);
    sel(); byte_x(8'h3A);
    byte_x(8'h00, 1, 8'h11, "R8 R7 rd 3FE");
    byte_x(8'h00, 1, 8'h22, "R8 R7 rd 3FF");
    byte_x(8'h00, 1, 8'h33, "R8 R7 rd 000");
    desel();
    check("R8 rd_ptr default window", rd_ptr, 10'h001);

    cmd2(8'h42, 8'h10); cmd2(8'h43, 8'h00);
    sel(); byte_x(8'h7A); byte_x(8'hA1); byte_x(8'hA2); byte_x(8'hA3); desel();
    check("R7 wr_ptr burst", wr_ptr, 10'h013);
    cmd2(8'h48, 8'h10); cmd2(8'h49, 8'h00); cmd2(8'h4A, 8'h12); cmd2(8'h4B, 8'h00);
    cmd2(8'h40, 8'h11); cmd2(8'h41, 8'h00);
    sel(); byte_x(8'h3A);
    byte_x(8'h00, 1, 8'hA2, "R8 wrap b0");
    byte_x(8'h00, 1, 8'hA3, "R8 wrap b1");
    byte_x(8'h00, 1, 8'hA1, "R8 wrap b2");
    byte_x(8'h00, 1, 8'hA2, "R8 wrap b3");
    byte_x(8'h00, 1, 8'hA3, "R8 wrap b4");
    desel();
    check("R8 rd_ptr after wraps", rd_ptr, 10'h010);
    rd_fast(5'h00, 8'h10, "R12 rd_ptr low");
    rd_fast(5'h01, 8'h00, "R12 rd_ptr high");
    rd_fast(5'h03, 8'h00, "R12 wr_ptr high");

    partial(8'h45, 4);
    rd_fast(5'h05, 8'h2E, "R10 abort in command");
    sel(); byte_x(8'h45);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sck = 0; mosi = 1; repeat (2) @(negedge clk); sck = 1; repeat (2) @(negedge clk);
    end
    desel();
    rd_fast(5'h05, 8'h2E, "R10 abort in data");

    cmd2(8'h5E, 8'h55);
    sel(); byte_x(8'hFF); desel();
    rd_fast(5'h05, 8'h00, "R9 reg cleared");
    rd_fast(5'h1E, 8'h55, "R9 clkout kept");
    rd_fast(5'h0A, 8'hFF, "R9 R1 window end low");
    rd_fast(5'h0B, 8'h03, "R9 R1 window end high");
    check("R9 rd_ptr", rd_ptr, 0);
    check("R9 wr_ptr", wr_ptr, 0);

    repeat (4) @(negedge clk);
    check("R3 R4 all read bytes compared", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule